// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block is an iterative multiplier for 32-bit operands. It returns the low word of the product, optionally added to a starting addend. Each busy cycle it looks at the next two multiplier bits and at one Booth carry bit held over from the previous cycle. From these it picks one of three terms: nothing, the multiplicand, or the multiplicand doubled. It then adds that term to, or subtracts it from, a 32-bit running sum. The multiplicand is weighted by four more on every cycle, so a full operand needs sixteen steps.

A single `start_i` pulse loads the operands. `busy_o` stays high while the steps run. `done_o` pulses for one cycle when `product_o` is valid, and `product_o` then holds until the next accepted start. The run stops as soon as the remaining multiplier bits are all zero and the carry is clear, so short multipliers finish in fewer cycles.

Top module: `booth_seq_mul`

## Requirements
- R1: When `done_o` is high, `product_o` equals (mcand × mplier + (acc_en ? addend : 0)) mod 2^32, where the operands are the values captured at the accepted start and are read as unsigned or as two's complement alike.
- R2: `done_o` is high for exactly one cycle per operation, `busy_o` is low in that cycle, and another start is accepted in that cycle.
- R3: A `start_i` that arrives while `busy_o` is high has no effect: the running operation keeps its operands, its step count and its result.
- R4: The number of busy steps is the smallest k in 1..16 for which mplier >> (2k−1) is zero, and 16 if there is no such k. With start accepted at edge t, `done_o` rises at edge t+k.
- R5: A multiplier that is zero still takes one step, and its result equals the addend (or 0 when accumulation is off).
- R6: Each step is chosen by {carry, mplier[2n+1:2n]}: 000 gives +0, carry 0; 001 gives +B, carry 0; 010 gives −2B, carry 1; 011 gives −B, carry 1; 100 gives +B, carry 0; 101 gives +2B, carry 0; 110 gives −B, carry 1; 111 gives +0, carry 1. Here B is mcand·4^n and the carry starts at 0.
- R7: When `acc_en_i` is low at start, `addend_i` has no effect on the result.
- R8: After reset, `busy_o` and `done_o` are low and `product_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when the block is idle |
| acc_en_i | input | 1 | Seed the running sum with the addend |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| addend_i | input | 32 | Starting value for accumulation |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| product_o | output | 32 | Low word of the result |

## Verification
The operand table covers every recoding row. Multipliers of all ones, a lone top bit, and small values that end in a 10 pair make the result wrong if any sign, doubling or carry is mishandled. The same patterns also pin down when the run stops early, because the number of cycles is checked against a count worked out from the multiplier's highest set bit. Directed cases hit a zero multiplier, an addend with accumulation off, and a second start issued while busy. That last case tells a restarted run apart from an ignored request by checking both the result and the cycle count.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef struct packed {
    logic zero;  // term is 0
    logic dbl;   // term is 2B
    logic neg;   // subtract term
  } booth_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      carry_i,
  input  logic [1:0] pair_i,
  output booth_op_t op_o,
  output logic      carry_o
);
  always_comb begin
    op_o    = '{zero: 1'b0, dbl: 1'b0, neg: 1'b0};
    carry_o = 1'b0;
    unique case ({carry_i, pair_i})
      3'b000: op_o.zero = 1'b1;
      3'b001: ;
      3'b010: begin op_o.dbl = 1'b1; op_o.neg = 1'b1; carry_o = 1'b1; end
      3'b011: begin op_o.neg = 1'b1; carry_o = 1'b1; end
      3'b100: ;
      3'b101: op_o.dbl = 1'b1;
      3'b110: begin op_o.neg = 1'b1; carry_o = 1'b1; end
      3'b111: begin op_o.zero = 1'b1; carry_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/booth_accum.sv
module booth_accum
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_op_t        op_i,
  output logic [WIDTH-1:0] acc_o
);
  logic [WIDTH-1:0] term;

  always_comb begin
    if (op_i.zero)     term = '0;
    else if (op_i.dbl) term = {mcand_i[WIDTH-2:0], 1'b0};
    else               term = mcand_i;
    acc_o = op_i.neg ? acc_i - term : acc_i + term;
  end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             acc_en_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [WIDTH-1:0] addend_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] product_o
);
  localparam int unsigned NUM_STEPS = WIDTH / 2;
  localparam int unsigned CNT_W     = $clog2(NUM_STEPS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_STEPS - 1);

  logic             busy_q, done_q, carry_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] acc_q, mcand_q, mplier_q;

  booth_op_t        op;
  logic             carry_nxt;
  logic [WIDTH-1:0] acc_nxt, rest;
  logic             last;

  booth_recode u_recode (
    .carry_i (carry_q),
    .pair_i  (mplier_q[1:0]),
    .op_o    (op),
    .carry_o (carry_nxt)
  );

  booth_accum #(.WIDTH(WIDTH)) u_accum (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .op_i    (op),
    .acc_o   (acc_nxt)
  );

  assign rest = mplier_q >> 2;
  assign last = (cnt_q == LAST_CNT) || (rest == '0 && !carry_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      carry_q  <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q    <= acc_nxt;
        mcand_q  <= mcand_q << 2;
        mplier_q <= rest;
        carry_q  <= carry_nxt;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q   <= 1'b1;
        carry_q  <= 1'b0;
        cnt_q    <= '0;
        acc_q    <= acc_en_i ? addend_i : '0;
        mcand_q  <= mcand_i;
        mplier_q <= mplier_i;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = acc_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST_CNT));
  p_stop_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((mplier_q == '0 && !carry_q) || cnt_q == LAST_CNT));
  p_hold_on_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && op.zero) |=> (acc_q == $past(acc_q)));
endmodule

// File: tb/booth_seq_mul_tb.sv
module booth_seq_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [31:0] V_MCAND [NV] = '{32'h12345678, 32'hFFFFFFFF, 32'h00000007,
    32'hDEADBEEF, 32'h00001000, 32'h7FFFFFFF, 32'hCAFEF00D, 32'h00000055};
  localparam logic [31:0] V_MPLIER [NV] = '{32'h9ABCDEF0, 32'hFFFFFFFF, 32'h80000000,
    32'h00000002, 32'h00000006, 32'h7FFFFFFF, 32'h00000003, 32'h00010000};
  localparam logic [31:0] V_ADDEND [NV] = '{32'h0, 32'h0, 32'h0,
    32'h11111111, 32'h00000005, 32'h0, 32'hFFFFFFFF, 32'h0};
  localparam logic V_ACC [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, acc_en = 1'b0;
  logic [31:0] mcand = '0, mplier = '0, addend = '0;
  logic busy, done;
  logic [31:0] product;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_seq_mul u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_en_i(acc_en),
    .mcand_i(mcand), .mplier_i(mplier), .addend_i(addend),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_steps(input logic [31:0] m);
    for (int k = 1; k <= 16; k++)
      if (k == 16 || (m >> (2*k - 1)) == 32'h0) return k;
    return 16;
  endfunction

  // start at negedge; optional second start while busy; returns cycles to done
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic en, input logic poke, output int cyc);
    mcand = a; mplier = b; addend = c; acc_en = en; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      if (poke && cyc == 0) begin
        mcand = 32'h5; mplier = 32'h0; addend = 32'h99; acc_en = 1'b1; start = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 100) check(1'b0, "watchdog", 32'(cyc), 32'd0);
  endtask

  initial begin
    int cyc;
    logic [31:0] exp;
    #(3*CLK_PERIOD + 2);
    // R8 reset state
    check(busy == 1'b0 && done == 1'b0, "R8 flags after reset", {30'd0, busy, done}, 32'd0);
    check(product == 32'h0, "R8 product after reset", product, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R6 table walk
    for (int i = 0; i < NV; i++) begin
      run_op(V_MCAND[i], V_MPLIER[i], V_ADDEND[i], V_ACC[i], 1'b0, cyc);
      exp = V_MCAND[i] * V_MPLIER[i] + (V_ACC[i] ? V_ADDEND[i] : 32'h0);
      check(product == exp, "R1 R6 product", product, exp);
      check(cyc == exp_steps(V_MPLIER[i]), "R4 step count", 32'(cyc), 32'(exp_steps(V_MPLIER[i])));
      @(negedge clk);
      // R2 one-cycle pulse, idle
      check(done == 1'b0 && busy == 1'b0, "R2 done pulse width", {30'd0, busy, done}, 32'd0);
    end

    // R5 zero multiplier
    run_op(32'hABCD1234, 32'h0, 32'h00C0FFEE, 1'b1, 1'b0, cyc);
    check(product == 32'h00C0FFEE, "R5 zero multiplier result", product, 32'h00C0FFEE);
    check(cyc == 1, "R5 zero multiplier steps", 32'(cyc), 32'd1);
    @(negedge clk);

    // R7 addend ignored
    run_op(32'h00000003, 32'h00000009, 32'hFFFF0000, 1'b0, 1'b0, cyc);
    check(product == 32'd27, "R7 addend ignored", product, 32'd27);
    @(negedge clk);

    // R3 start while busy
    run_op(32'h00000101, 32'h40000000, 32'h00000002, 1'b1, 1'b1, cyc);
    exp = 32'h00000101 * 32'h40000000 + 32'h2;
    check(product == exp, "R3 result after busy start", product, exp);
    check(cyc == 16, "R3 steps after busy start", 32'(cyc), 32'd16);
    @(negedge clk);
    check(busy == 1'b0, "R3 no pending start", {31'd0, busy}, 32'd0);

    // R2 back-to-back: start accepted in done cycle
    mcand = 32'h6; mplier = 32'h7; addend = 32'h0; acc_en = 1'b0; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    while (!done) begin @(posedge clk); @(negedge clk); end
    mcand = 32'h9; mplier = 32'h9; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2 start accepted on done cycle", {31'd0, busy}, 32'd1);
    while (!done) begin @(posedge clk); @(negedge clk); end
    check(product == 32'd81, "R2 back-to-back result", product, 32'd81);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule